// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a 64-word by 36-bit first-in first-out store that connects two unrelated clock domains. Port A runs on the write clock and only writes. Port B runs on the read clock and only reads. Each port has four qualifiers: an active-low chip select, a direction select, an enable and a mailbox select. A port acts only when all four qualifiers take their transfer values. A write is also blocked when the store is full, and a read is blocked when it is empty.

Each domain builds its own flags. The write side drives a full flag and an almost-full flag. The read side drives an empty flag and an almost-empty flag. To do this, each side compares its own pointer with a synchronized copy of the pointer from the other domain. The threshold for both "almost" flags comes from a two-bit level select that is sampled when the asynchronous reset is released.

A read loads the word into an output register, and the register keeps that word until the next read.

Top module: `xfifo36`

## Requirements
- R1: While `rst_n` is low, `full_n`, `empty_n` and `almost_empty_n` are low, `almost_full_n` is high and `b_data` is zero.
- R2: After `rst_n` rises, `full_n` stays low through the first rising `wclk` edge and is high after the second.
- R3: On the rising edge of `rst_n` the threshold is taken from `lvl_sel`: 2'b00 selects 4, 2'b01 selects 8, 2'b10 selects 12 and 2'b11 selects 16.
- R4: A word is stored on a rising `wclk` edge only when `a_cs_n`=0, `a_dir`=1, `a_en`=1, `a_mbx`=0 and `full_n`=1. Any other combination stores nothing.
- R5: A word is read on a rising `rclk` edge only when `b_cs_n`=0, `b_dir`=0, `b_en`=1, `b_mbx`=0 and `empty_n`=1. Any other combination reads nothing and leaves `b_data` unchanged.
- R6: Words come out on `b_data` in the order they were stored, each one on the `rclk` edge that reads it.
- R7: With 64 words stored, `full_n` is low and further writes are dropped. `full_n` rises again once a read has been seen by the write domain.
- R8: With no words stored, `empty_n` is low and read attempts change neither `b_data` nor the stored contents.
- R9: Once the domains have settled, `almost_empty_n` is low when the stored count is at most the threshold, and high otherwise.
- R10: Once the domains have settled, `almost_full_n` is low when the free space (64 minus the count) is at most the threshold, and high otherwise.
- R11: `b_data` holds its value on every `rclk` edge with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset; its rising edge latches the threshold |
| lvl_sel | input | 2 | Threshold select for the almost flags |
| a_cs_n | input | 1 | Port A select, active low |
| a_dir | input | 1 | Port A direction, 1 = write |
| a_en | input | 1 | Port A enable |
| a_mbx | input | 1 | Port A mailbox select; must be 0 for a FIFO write |
| a_data | input | 36 | Write data |
| full_n | output | 1 | Low when the store is full |
| almost_full_n | output | 1 | Low when free space is at most the threshold |
| b_cs_n | input | 1 | Port B select, active low |
| b_dir | input | 1 | Port B direction, 0 = read |
| b_en | input | 1 | Port B enable |
| b_mbx | input | 1 | Port B mailbox select; must be 0 for a FIFO read |
| b_data | output | 36 | Registered read data |
| empty_n | output | 1 | Low when the store is empty |
| almost_empty_n | output | 1 | Low when the count is at most the threshold |

## Verification
The hardest states to reach from the ports are the edges of the almost-full threshold for every threshold value. Each one needs a fresh reset with a different select, followed by a precise fill of nearly the whole store. The stimulus resets once for each select value, writes exactly the threshold count and then one more word to test the almost-empty edge, and then fills to one word short of the almost-full edge and to the edge itself. After each step it waits long enough for both synchronizers to settle before it samples the flags. A separate pass fills the store completely, offers one extra word, and drains the store to show that the extra word was dropped and that order was kept.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;
  localparam int OFS_W = 5;
  typedef logic [OFS_W-1:0] ofs_t;

  // threshold = 4 * (select + 1)
  function automatic ofs_t offset_of(input logic [1:0] sel);
    return ofs_t'({1'b0, sel} + 3'd1) << 2;
  endfunction
endpackage

// File: rtl/xfifo_sync.sv
module xfifo_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= din;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/xfifo_wside.sv
module xfifo_wside #(
  parameter int ADDR_W = 6,
  localparam int PTR_W = ADDR_W + 1
) (
  input  logic             wclk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             dir,
  input  logic             en,
  input  logic             mbx,
  input  logic [PTR_W-1:0] offset,
  input  logic [PTR_W-1:0] rgray_sync,
  output logic             wr_fire,
  output logic [PTR_W-1:0] wptr_bin,
  output logic [PTR_W-1:0] wgray,
  output logic [PTR_W-1:0] wr_level,
  output logic             full_n,
  output logic             almost_full_n
);
  localparam int DEPTH = 1 << ADDR_W;

  function automatic logic [PTR_W-1:0] to_gray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] from_gray(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [PTR_W-1:0] space_left(input logic [PTR_W-1:0] lvl);
    return PTR_W'(DEPTH) - lvl;
  endfunction

  logic             awake;
  logic             wr_req;
  logic [PTR_W-1:0] rptr_seen;
  logic [PTR_W-1:0] ptr_next;
  logic [PTR_W-1:0] level_next;

  assign wr_req     = !cs_n && dir && en && !mbx;
  assign wr_fire    = wr_req && full_n;
  assign rptr_seen  = from_gray(rgray_sync);
  assign ptr_next   = wptr_bin + PTR_W'(wr_fire);
  assign level_next = ptr_next - rptr_seen;
  assign wr_level   = wptr_bin - rptr_seen;

  // one flop of release delay so full_n rises on the second edge
  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) awake <= 1'b0;
    else        awake <= 1'b1;
  end

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_bin      <= '0;
      wgray         <= '0;
      full_n        <= 1'b0;
      almost_full_n <= 1'b1;
    end else begin
      wptr_bin      <= ptr_next;
      wgray         <= to_gray(ptr_next);
      full_n        <= awake && (level_next != PTR_W'(DEPTH));
      almost_full_n <= space_left(level_next) > offset;
    end
  end
endmodule

// File: rtl/xfifo_rside.sv
module xfifo_rside #(
  parameter int ADDR_W = 6,
  localparam int PTR_W = ADDR_W + 1
) (
  input  logic             rclk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             dir,
  input  logic             en,
  input  logic             mbx,
  input  logic [PTR_W-1:0] offset,
  input  logic [PTR_W-1:0] wgray_sync,
  output logic             rd_fire,
  output logic [PTR_W-1:0] rptr_bin,
  output logic [PTR_W-1:0] rgray,
  output logic             empty_n,
  output logic             almost_empty_n
);
  function automatic logic [PTR_W-1:0] to_gray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] from_gray(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic             awake;
  logic             rd_req;
  logic [PTR_W-1:0] wptr_seen;
  logic [PTR_W-1:0] ptr_next;
  logic [PTR_W-1:0] level_next;

  assign rd_req     = !cs_n && !dir && en && !mbx;
  assign rd_fire    = rd_req && empty_n;
  assign wptr_seen  = from_gray(wgray_sync);
  assign ptr_next   = rptr_bin + PTR_W'(rd_fire);
  assign level_next = wptr_seen - ptr_next;

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) awake <= 1'b0;
    else        awake <= 1'b1;
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_bin       <= '0;
      rgray          <= '0;
      empty_n        <= 1'b0;
      almost_empty_n <= 1'b0;
    end else begin
      rptr_bin       <= ptr_next;
      rgray          <= to_gray(ptr_next);
      empty_n        <= awake && (level_next != '0);
      almost_empty_n <= level_next > offset;
    end
  end
endmodule

// File: rtl/xfifo_ram.sv
module xfifo_ram #(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 6,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/xfifo36.sv
module xfifo36 #(
  parameter int DATA_W      = 36,
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic [1:0]        lvl_sel,
  input  logic              a_cs_n,
  input  logic              a_dir,
  input  logic              a_en,
  input  logic              a_mbx,
  input  logic [DATA_W-1:0] a_data,
  output logic              full_n,
  output logic              almost_full_n,
  input  logic              b_cs_n,
  input  logic              b_dir,
  input  logic              b_en,
  input  logic              b_mbx,
  output logic [DATA_W-1:0] b_data,
  output logic              empty_n,
  output logic              almost_empty_n
);
  import xfifo_pkg::*;
  localparam int PTR_W = ADDR_W + 1;

  ofs_t             lvl_offset;
  logic [PTR_W-1:0] offset_w;
  logic             wr_fire;
  logic             rd_fire;
  logic [PTR_W-1:0] wr_ptr_bin;
  logic [PTR_W-1:0] rd_ptr_bin;
  logic [PTR_W-1:0] wr_gray;
  logic [PTR_W-1:0] rd_gray;
  logic [PTR_W-1:0] wr_gray_at_r;
  logic [PTR_W-1:0] rd_gray_at_w;
  logic [PTR_W-1:0] wr_level;

  // threshold captured as reset is released
  always_ff @(posedge rst_n) lvl_offset <= offset_of(lvl_sel);
  assign offset_w = PTR_W'(lvl_offset);

  xfifo_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wclk), .rst_n(rst_n), .din(rd_gray), .dout(rd_gray_at_w));

  xfifo_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rclk), .rst_n(rst_n), .din(wr_gray), .dout(wr_gray_at_r));

  xfifo_wside #(.ADDR_W(ADDR_W)) u_wside (
    .wclk(wclk), .rst_n(rst_n), .cs_n(a_cs_n), .dir(a_dir), .en(a_en), .mbx(a_mbx),
    .offset(offset_w), .rgray_sync(rd_gray_at_w), .wr_fire(wr_fire),
    .wptr_bin(wr_ptr_bin), .wgray(wr_gray), .wr_level(wr_level),
    .full_n(full_n), .almost_full_n(almost_full_n));

  xfifo_rside #(.ADDR_W(ADDR_W)) u_rside (
    .rclk(rclk), .rst_n(rst_n), .cs_n(b_cs_n), .dir(b_dir), .en(b_en), .mbx(b_mbx),
    .offset(offset_w), .wgray_sync(wr_gray_at_r), .rd_fire(rd_fire),
    .rptr_bin(rd_ptr_bin), .rgray(rd_gray),
    .empty_n(empty_n), .almost_empty_n(almost_empty_n));

  xfifo_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .wclk(wclk), .we(wr_fire), .waddr(wr_ptr_bin[ADDR_W-1:0]), .wdata(a_data),
    .rclk(rclk), .rst_n(rst_n), .re(rd_fire), .raddr(rd_ptr_bin[ADDR_W-1:0]),
    .rdata(b_data));
endmodule

// File: rtl/xfifo36_check.sv
module xfifo36_check #(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 6,
  localparam int PTR_W = ADDR_W + 1,
  localparam int DEPTH = 1 << ADDR_W
) (
  input logic              wclk,
  input logic              rclk,
  input logic              rst_n,
  input logic              full_n,
  input logic              almost_full_n,
  input logic              empty_n,
  input logic              almost_empty_n,
  input logic [DATA_W-1:0] b_data,
  input logic [PTR_W-1:0]  wr_ptr_bin,
  input logic [PTR_W-1:0]  rd_ptr_bin,
  input logic [PTR_W-1:0]  wr_gray,
  input logic [PTR_W-1:0]  wr_level,
  input logic              rd_fire,
  input logic [4:0]        lvl_offset
);
  assert_reset_wflags_R1: assert property (@(posedge wclk)
    !rst_n |-> (!full_n && almost_full_n));

  assert_reset_rflags_R1: assert property (@(posedge rclk)
    !rst_n |-> (!empty_n && !almost_empty_n && b_data == '0));

  assert_offset_legal_R3: assert property (@(posedge wclk) disable iff (!rst_n)
    lvl_offset inside {5'd4, 5'd8, 5'd12, 5'd16});

  assert_gray_step_R6: assert property (@(posedge wclk) disable iff (!rst_n)
    $onehot0(wr_gray ^ $past(wr_gray)));

  assert_no_overflow_R7: assert property (@(posedge wclk) disable iff (!rst_n)
    !full_n |=> $stable(wr_ptr_bin));

  assert_level_bound_R7: assert property (@(posedge wclk) disable iff (!rst_n)
    wr_level <= PTR_W'(DEPTH));

  assert_no_underflow_R8: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |=> $stable(rd_ptr_bin));

  assert_data_hold_R11: assert property (@(posedge rclk) disable iff (!rst_n)
    !rd_fire |=> $stable(b_data));
endmodule

bind xfifo36 xfifo36_check #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
  .full_n(full_n), .almost_full_n(almost_full_n),
  .empty_n(empty_n), .almost_empty_n(almost_empty_n),
  .b_data(b_data), .wr_ptr_bin(wr_ptr_bin), .rd_ptr_bin(rd_ptr_bin),
  .wr_gray(wr_gray), .wr_level(wr_level), .rd_fire(rd_fire),
  .lvl_offset(lvl_offset));

// File: tb/xfifo36_test.sv
module xfifo36_test;
  localparam int WCLK_PERIOD = 10;
  localparam int RCLK_PERIOD = 14;
  localparam int DEPTH       = 64;

  logic        wclk = 1'b0;
  logic        rclk = 1'b0;
  logic        rst_n;
  logic [1:0]  lvl_sel;
  logic        a_cs_n, a_dir, a_en, a_mbx;
  logic [35:0] a_data;
  logic        full_n, almost_full_n;
  logic        b_cs_n, b_dir, b_en, b_mbx;
  logic [35:0] b_data;
  logic        empty_n, almost_empty_n;

  always #(WCLK_PERIOD/2) wclk = ~wclk;
  always #(RCLK_PERIOD/2) rclk = ~rclk;

  xfifo36 uut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .lvl_sel(lvl_sel),
    .a_cs_n(a_cs_n), .a_dir(a_dir), .a_en(a_en), .a_mbx(a_mbx), .a_data(a_data),
    .full_n(full_n), .almost_full_n(almost_full_n),
    .b_cs_n(b_cs_n), .b_dir(b_dir), .b_en(b_en), .b_mbx(b_mbx), .b_data(b_data),
    .empty_n(empty_n), .almost_empty_n(almost_empty_n));

  logic [35:0] sb [$];
  logic [35:0] last_read = '0;
  int unsigned reads_seen = 0;
  int unsigned wr_seq = 0;
  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  bit          run_done = 1'b0;

  task automatic chk(input string tag, input longint act, input longint exp, input string what);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // monitor: every qualified read edge pops the scoreboard (R6)
  always @(posedge rclk) begin
    if (rst_n && !b_cs_n && !b_dir && b_en && !b_mbx && empty_n) begin
      reads_seen++;
      #1;
      if (sb.size() == 0) begin
        n_vec++;
        n_bad++;
        $display("FAIL R6 unexpected read: actual %0h expected none", b_data);
      end else begin
        logic [35:0] e;
        e = sb.pop_front();
        chk("R6", b_data, e, "read order");
        last_read = e;
      end
    end
  end

  task automatic idle_a();
    a_cs_n = 1'b1; a_dir = 1'b0; a_en = 1'b0; a_mbx = 1'b0;
  endtask

  task automatic idle_b();
    b_cs_n = 1'b1; b_dir = 1'b1; b_en = 1'b0; b_mbx = 1'b0;
  endtask

  // driver: offers one word per write-clock edge, pushes it if accepted
  task automatic put_word();
    logic [35:0] d;
    d = (36'(wr_seq) * 36'h9_E377_9B1) ^ 36'hA_5A5A_5A5A;
    wr_seq++;
    @(negedge wclk);
    a_cs_n = 1'b0; a_dir = 1'b1; a_en = 1'b1; a_mbx = 1'b0; a_data = d;
    if (full_n) sb.push_back(d);
  endtask

  task automatic put_n(input int n);
    for (int i = 0; i < n; i++) put_word();
    @(negedge wclk);
    idle_a();
  endtask

  task automatic get_n(input int n);
    int unsigned target;
    target = reads_seen + n;
    @(negedge rclk);
    b_cs_n = 1'b0; b_dir = 1'b0; b_en = 1'b1; b_mbx = 1'b0;
    while (reads_seen < target) @(negedge rclk);
    idle_b();
  endtask

  task automatic settle();
    repeat (8) @(negedge rclk);
    @(negedge wclk);
  endtask

  task automatic do_reset(input logic [1:0] sel);
    @(negedge wclk);
    rst_n = 1'b0;
    lvl_sel = sel;
    idle_a();
    idle_b();
    repeat (5) @(negedge rclk);
    chk("R1", full_n, 0, "full_n in reset");
    chk("R1", almost_full_n, 1, "almost_full_n in reset");
    chk("R1", empty_n, 0, "empty_n in reset");
    chk("R1", almost_empty_n, 0, "almost_empty_n in reset");
    chk("R1", b_data, 0, "b_data in reset");
    sb.delete();
    last_read = '0;
    @(negedge wclk);
    rst_n = 1'b1;
    @(posedge wclk); #1;
    chk("R2", full_n, 0, "full_n after first edge");
    @(posedge wclk); #1;
    chk("R2", full_n, 1, "full_n after second edge");
    settle();
  endtask

  initial begin
    #(WCLK_PERIOD * 150000);
    if (!run_done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b1;
    lvl_sel = 2'b00;
    a_data = '0;
    idle_a();
    idle_b();
    #2 rst_n = 1'b0;

    do_reset(2'b01); // threshold 8

    // R8: reads while empty do nothing
    @(negedge rclk);
    b_cs_n = 1'b0; b_dir = 1'b0; b_en = 1'b1; b_mbx = 1'b0;
    repeat (3) @(negedge rclk);
    idle_b();
    chk("R8", reads_seen, 0, "reads while empty");
    chk("R8", b_data, 0, "b_data after empty reads");

    // R4: each disqualified write pattern stores nothing
    for (int p = 0; p < 4; p++) begin
      @(negedge wclk);
      a_cs_n = (p == 0); a_dir = (p != 1); a_en = (p != 2); a_mbx = (p == 3);
      a_data = '1;
    end
    @(negedge wclk);
    idle_a();
    settle();
    chk("R4", empty_n, 0, "empty_n after blocked writes");
    chk("R4", almost_full_n, 1, "almost_full_n after blocked writes");

    put_n(8);
    settle();
    chk("R9", almost_empty_n, 0, "almost_empty_n at count 8");
    chk("R10", almost_full_n, 1, "almost_full_n at count 8");
    put_n(1);
    settle();
    chk("R9", almost_empty_n, 1, "almost_empty_n at count 9");
    chk("R8", empty_n, 1, "empty_n with data");

    // R5: each disqualified read pattern reads nothing
    for (int p = 0; p < 4; p++) begin
      @(negedge rclk);
      b_cs_n = (p == 0); b_dir = (p == 1); b_en = (p != 2); b_mbx = (p == 3);
    end
    @(negedge rclk);
    idle_b();
    settle();
    chk("R5", reads_seen, 0, "blocked reads");
    chk("R5", b_data, 0, "b_data after blocked reads");

    put_n(46);
    settle();
    chk("R10", almost_full_n, 1, "almost_full_n at count 55");
    put_n(1);
    settle();
    chk("R10", almost_full_n, 0, "almost_full_n at count 56");
    put_n(7);
    chk("R7", full_n, 1, "full_n at count 63");
    put_n(1);
    chk("R7", full_n, 0, "full_n at count 64");
    put_n(1);
    chk("R7", sb.size(), 64, "words accepted when full");

    get_n(1);
    repeat (6) @(negedge rclk);
    chk("R11", b_data, last_read, "b_data hold while idle");
    settle();
    chk("R7", full_n, 1, "full_n after one read");

    get_n(63);
    settle();
    chk("R8", empty_n, 0, "empty_n after drain");
    chk("R6", sb.size(), 0, "words left in scoreboard");

    @(negedge rclk);
    b_cs_n = 1'b0; b_dir = 1'b0; b_en = 1'b1; b_mbx = 1'b0;
    repeat (3) @(negedge rclk);
    idle_b();
    chk("R8", b_data, last_read, "b_data after reads on empty");

    // R3: every select value sets both thresholds
    for (int s = 0; s < 4; s++) begin
      int k;
      k = 4 + 4 * s;
      do_reset(2'(s));
      put_n(k);
      settle();
      chk("R3", almost_empty_n, 0, $sformatf("almost_empty_n sel %0d at count %0d", s, k));
      put_n(1);
      settle();
      chk("R3", almost_empty_n, 1, $sformatf("almost_empty_n sel %0d at count %0d", s, k + 1));
      put_n(DEPTH - 2 * k - 2);
      settle();
      chk("R3", almost_full_n, 1, $sformatf("almost_full_n sel %0d free %0d", s, k + 1));
      put_n(1);
      settle();
      chk("R3", almost_full_n, 0, $sformatf("almost_full_n sel %0d free %0d", s, k));
      get_n(DEPTH - k);
      settle();
      chk("R6", sb.size(), 0, "scoreboard after drain");
      chk("R8", empty_n, 0, "empty_n after drain");
    end

    run_done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule